// File: doc/BRIEF.md
# Fault-Injectable Bit RAM

This block is a small synchronous RAM with one bit per cell. On command it behaves like a defective memory, so that built-in memory test logic can be tried against known defects. While no access is in progress, a configuration port loads a fault type, a victim cell and, where the fault needs one, an aggressor cell. It also loads two control bits: a trigger bit and a forced value. From then on, ordinary reads and writes through the access port show the behaviour of the chosen defect. Fault type zero, and any code the block does not define, gives a fault-free memory.

Only one fault is active at a time. The supported defects are single-cell static faults, two-cell coupling faults and bridging between two cells. All of them act on real access cycles, and none has a timing element. A read returns its data one cycle after the request. Only the victim and the aggressor ever differ from an ideal memory.

Top module: `fault_inj_ram`

## Requirements
- R1: After reset the configuration is type 0 (ideal), every cell holds 0, and `rdValid` is low.
- R2: A read with `memEn`=1 and `memWe`=0 raises `rdValid` and presents `rdData` on the cycle after the request, and `rdValid` is low after any other cycle. Under type 0, and under the unused codes 12 to 15, every read returns the last value written to that cell.
- R3: The configuration inputs are captured only on a cycle where `cfgWe`=1 and `memEn`=0. A `cfgWe` pulse while an access is in progress is ignored.
- R4: Type 1 (stuck-at): the victim always reads back `cfgVal`, whatever is written to it.
- R5: Type 2 (transition): with `cfgTrig`=1, a write of 1 into a victim that holds 0 leaves it at 0. With `cfgTrig`=0, a write of 0 into a victim that holds 1 leaves it at 1. All other writes behave normally.
- R6: Type 3 (read disturb): a read of the victim returns the inverse of the stored bit, and the stored bit is inverted.
- R7: Type 4 (deceptive read disturb): a read of the victim returns the stored bit and then inverts it, so a second back-to-back read returns the opposite value.
- R8: Type 5 (incorrect read): a read of the victim returns the inverse of the stored bit, and the stored bit is unchanged.
- R9: Type 6 (write disturb): a write to the victim of the value it already holds stores the inverse instead.
- R10: Type 7 (inversion coupling): a write that takes the aggressor to `cfgTrig` from the opposite value inverts the victim. A value of 1 means a rising edge and 0 a falling edge.
- R11: Type 8 (idempotent coupling): the same aggressor transition as in R10 sets the victim to `cfgVal`.
- R12: Type 9 (state coupling): while the aggressor holds `cfgTrig`, reads of the victim return `cfgVal`. Otherwise they return the stored victim bit.
- R13: Type 10 (AND bridge) and type 11 (OR bridge): a read of either the victim or the aggressor returns the AND or the OR of the two stored bits. Writes are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Load the configuration (honoured only when idle) |
| cfgType | input | 4 | Fault type code |
| cfgVictim | input | ADDR_W | Victim cell address |
| cfgAggr | input | ADDR_W | Aggressor cell address |
| cfgTrig | input | 1 | Transition direction or aggressor state |
| cfgVal | input | 1 | Forced value |
| memEn | input | 1 | Access request |
| memWe | input | 1 | 1 = write, 0 = read |
| memAddr | input | ADDR_W | Access address |
| memWdata | input | 1 | Write data |
| rdValid | output | 1 | Read data valid, one cycle after the request |
| rdData | output | 1 | Read data |

## Verification
A wrong stored bit in the array stays hidden until that cell is read. It then shows on `rdData` one cycle after the read request. For coupling faults this means the victim must be read after the aggressor is written. For deceptive read disturb it means a second back-to-back read. A wrong configuration register changes how every later access to the victim behaves. The bench therefore drives random mixes of accesses that are biased towards the victim and the aggressor, under every fault type. It compares each read against a bench model, so a corrupted bit is caught at the first read of that cell that follows.

// File: rtl/fault_inj_pkg.sv
package fault_inj_pkg;

  typedef enum logic [3:0] {
    FT_NONE    = 4'd0,
    FT_STUCK   = 4'd1,
    FT_TRANS   = 4'd2,
    FT_RDIST   = 4'd3,
    FT_DRDIST  = 4'd4,
    FT_INCRD   = 4'd5,
    FT_WDIST   = 4'd6,
    FT_CINV    = 4'd7,
    FT_CIDEM   = 4'd8,
    FT_CSTATE  = 4'd9,
    FT_BAND    = 4'd10,
    FT_BOR     = 4'd11
  } fault_e;

  typedef struct packed {
    logic [3:0] ftype;
    logic       trig;
    logic       val;
  } cfg_t;

  // Control-to-array strobes for one access cycle.
  typedef struct packed {
    logic wrEn;   // update addressed cell
    logic wrBit;
    logic vicEn;  // side-effect update of the victim cell
    logic vicBit;
    logic rdEn;   // register read data
    logic rdBit;
  } strobe_t;

endpackage

// File: rtl/fault_inj_ctrl.sv
module fault_inj_ctrl
  import fault_inj_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [3:0]        cfgType,
  input  logic [ADDR_W-1:0] cfgVictim,
  input  logic [ADDR_W-1:0] cfgAggr,
  input  logic              cfgTrig,
  input  logic              cfgVal,
  input  logic              memEn,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memWdata,
  input  logic              curBit,
  input  logic              vicBit,
  input  logic              aggBit,
  output cfg_t              cfgQ,
  output logic [ADDR_W-1:0] vicQ,
  output logic [ADDR_W-1:0] aggQ,
  output strobe_t           stb
);

  logic rdReq, wrReq, isVic, isAgg, aggEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
      vicQ <= '0;
      aggQ <= '0;
    end else if (cfgWe && !memEn) begin
      cfgQ <= '{ftype: cfgType, trig: cfgTrig, val: cfgVal};
      vicQ <= cfgVictim;
      aggQ <= cfgAggr;
    end
  end

  assign rdReq   = memEn && !memWe;
  assign wrReq   = memEn && memWe;
  assign isVic   = (memAddr == vicQ);
  assign isAgg   = (memAddr == aggQ);
  assign aggEdge = isAgg && !isVic && (curBit != memWdata) && (memWdata == cfgQ.trig);

  always_comb begin
    stb        = '0;
    stb.wrEn   = wrReq;
    stb.wrBit  = memWdata;
    stb.rdEn   = rdReq;
    stb.rdBit  = curBit;
    stb.vicBit = vicBit;
    if (wrReq) begin
      case (cfgQ.ftype)
        FT_STUCK: if (isVic) stb.wrBit = cfgQ.val;
        FT_TRANS: begin
          if (isVic && cfgQ.trig && !curBit && memWdata) stb.wrBit = 1'b0;
          if (isVic && !cfgQ.trig && curBit && !memWdata) stb.wrBit = 1'b1;
        end
        FT_WDIST: if (isVic && (memWdata == curBit)) stb.wrBit = ~curBit;
        FT_CINV: if (aggEdge) begin
          stb.vicEn  = 1'b1;
          stb.vicBit = ~vicBit;
        end
        FT_CIDEM: if (aggEdge) begin
          stb.vicEn  = 1'b1;
          stb.vicBit = cfgQ.val;
        end
        default: ;
      endcase
    end else if (rdReq) begin
      case (cfgQ.ftype)
        FT_STUCK: if (isVic) stb.rdBit = cfgQ.val;
        FT_RDIST: if (isVic) begin
          stb.rdBit = ~curBit;
          stb.wrEn  = 1'b1;
          stb.wrBit = ~curBit;
        end
        FT_DRDIST: if (isVic) begin
          stb.wrEn  = 1'b1;
          stb.wrBit = ~curBit;
        end
        FT_INCRD: if (isVic) stb.rdBit = ~curBit;
        FT_CSTATE: if (isVic && (aggBit == cfgQ.trig)) stb.rdBit = cfgQ.val;
        FT_BAND: if (isVic || isAgg) stb.rdBit = vicBit & aggBit;
        FT_BOR: if (isVic || isAgg) stb.rdBit = vicBit | aggBit;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fault_inj_array.sv
module fault_inj_array
  import fault_inj_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] vicAddr,
  input  logic [ADDR_W-1:0] aggAddr,
  output logic              curBit,
  output logic              vicBit,
  output logic              aggBit,
  output logic              rdValid,
  output logic              rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] cells;

  assign curBit = cells[addr];
  assign vicBit = cells[vicAddr];
  assign aggBit = cells[aggAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cells   <= '0;
      rdValid <= 1'b0;
      rdData  <= 1'b0;
    end else begin
      if (stb.wrEn) cells[addr] <= stb.wrBit;
      if (stb.vicEn) cells[vicAddr] <= stb.vicBit;
      rdValid <= stb.rdEn;
      if (stb.rdEn) rdData <= stb.rdBit;
    end
  end

endmodule

// File: rtl/fault_inj_ram.sv
module fault_inj_ram
  import fault_inj_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [3:0]        cfgType,
  input  logic [ADDR_W-1:0] cfgVictim,
  input  logic [ADDR_W-1:0] cfgAggr,
  input  logic              cfgTrig,
  input  logic              cfgVal,
  input  logic              memEn,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memWdata,
  output logic              rdValid,
  output logic              rdData
);

  cfg_t              cfgQ;
  logic [ADDR_W-1:0] vicQ, aggQ;
  strobe_t           stb;
  logic              curBit, vicBit, aggBit;

  fault_inj_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgType(cfgType),
    .cfgVictim(cfgVictim), .cfgAggr(cfgAggr), .cfgTrig(cfgTrig), .cfgVal(cfgVal),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .curBit(curBit), .vicBit(vicBit), .aggBit(aggBit),
    .cfgQ(cfgQ), .vicQ(vicQ), .aggQ(aggQ), .stb(stb)
  );

  fault_inj_array #(.ADDR_W(ADDR_W)) uArray (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(memAddr),
    .vicAddr(vicQ), .aggAddr(aggQ),
    .curBit(curBit), .vicBit(vicBit), .aggBit(aggBit),
    .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: rtl/fault_inj_ram_chk.sv
module fault_inj_ram_chk
  import fault_inj_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              memEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWdata,
  input logic              rdValid,
  input logic              rdData,
  input cfg_t              cfgQ,
  input logic [ADDR_W-1:0] vicQ,
  input strobe_t           stb
);

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |=> rdValid); // R2
  AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rstN)
    !(memEn && !memWe) |=> !rdValid); // R2
  AST_IDEAL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe && cfgQ.ftype == FT_NONE) |-> (stb.wrBit == memWdata && !stb.vicEn)); // R2
  AST_CFG_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    memEn |=> ($stable(cfgQ) && $stable(vicQ))); // R3
  AST_STUCK_READ: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe && cfgQ.ftype == FT_STUCK && memAddr == vicQ) |=> (rdData == $past(cfgQ.val))); // R4
  AST_COUPLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    stb.vicEn |-> (cfgQ.ftype == FT_CINV || cfgQ.ftype == FT_CIDEM)); // R10

endmodule

bind fault_inj_ram fault_inj_ram_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .rdValid(rdValid), .rdData(rdData),
  .cfgQ(cfgQ), .vicQ(vicQ), .stb(stb)
);

// File: tb/fault_inj_ram_test.sv
module fault_inj_ram_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 1'b0, cfgTrig = 1'b0, cfgVal = 1'b0;
  logic [3:0] cfgType = '0;
  logic [ADDR_W-1:0] cfgVictim = '0, cfgAggr = '0, memAddr = '0;
  logic memEn = 1'b0, memWe = 1'b0, memWdata = 1'b0;
  logic rdValid, rdData;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  bit [DEPTH-1:0] m;
  int mT = 0;
  int mV = 0, mA = 0;
  bit mTrig = 1'b0, mVal = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_inj_ram #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgType(cfgType),
    .cfgVictim(cfgVictim), .cfgAggr(cfgAggr), .cfgTrig(cfgTrig), .cfgVal(cfgVal),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .rdValid(rdValid), .rdData(rdData)
  );

  function automatic string tagOf(int t);
    case (t)
      1: return "R4";  2: return "R5";  3: return "R6";  4: return "R7";
      5: return "R8";  6: return "R9";  7: return "R10"; 8: return "R11";
      9: return "R12"; 10, 11: return "R13";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected read result per requirement, updating the model cells.
  function automatic bit modelRead(int a);
    bit cur = m[a];
    bit res = cur;
    case (mT)
      1: if (a == mV) res = mVal;
      3: if (a == mV) begin res = ~cur; m[a] = ~cur; end
      4: if (a == mV) m[a] = ~cur;
      5: if (a == mV) res = ~cur;
      9: if (a == mV && m[mA] == mTrig) res = mVal;
      10: if (a == mV || a == mA) res = m[mV] & m[mA];
      11: if (a == mV || a == mA) res = m[mV] | m[mA];
      default: ;
    endcase
    return res;
  endfunction

  function automatic void modelWrite(int a, bit d);
    bit cur = m[a];
    bit nb = d;
    case (mT)
      1: if (a == mV) nb = mVal;
      2: if (a == mV) begin
        if (mTrig && !cur && d) nb = 1'b0;
        if (!mTrig && cur && !d) nb = 1'b1;
      end
      6: if (a == mV && d == cur) nb = ~cur;
      default: ;
    endcase
    m[a] = nb;
    if ((mT == 7 || mT == 8) && a == mA && a != mV && cur != d && d == mTrig)
      m[mV] = (mT == 7) ? ~m[mV] : mVal;
  endfunction

  task automatic setCfg(int t, int v, int a, bit tr, bit vl);
    cfgWe = 1'b1; cfgType = 4'(t); cfgVictim = ADDR_W'(v); cfgAggr = ADDR_W'(a);
    cfgTrig = tr; cfgVal = vl; memEn = 1'b0;
    @(negedge clk);
    cfgWe = 1'b0;
    mT = t; mV = v; mA = a; mTrig = tr; mVal = vl;
  endtask

  task automatic op(bit we, int a, bit d, string req);
    bit exp = 1'b0;
    memEn = 1'b1; memWe = we; memAddr = ADDR_W'(a); memWdata = d;
    if (we) modelWrite(a, d); else exp = modelRead(a);
    @(negedge clk);
    memEn = 1'b0;
    if (!we) begin
      check(req, rdValid, 1'b1);
      check(req, rdData, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    m = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", rdValid, 1'b0);
    for (int i = 0; i < DEPTH; i++) op(1'b0, i, 1'b0, "R1");

    // R2: ideal behaviour and idle rdValid
    op(1'b1, 5, 1'b1, "R2");
    check("R2", rdValid, 1'b0);
    op(1'b0, 5, 1'b0, "R2");
    op(1'b0, 4, 1'b0, "R2");

    // R3: cfgWe during an access is ignored
    memEn = 1'b1; memWe = 1'b0; memAddr = 4'd2;
    cfgWe = 1'b1; cfgType = 4'd1; cfgVictim = 4'd2; cfgVal = 1'b1;
    @(negedge clk);
    memEn = 1'b0; cfgWe = 1'b0;
    check("R3", rdData, 1'b0);
    op(1'b0, 2, 1'b0, "R3");
    setCfg(1, 2, 3, 1'b0, 1'b1);
    op(1'b0, 2, 1'b0, "R4");
    op(1'b1, 2, 1'b0, "R4");
    op(1'b0, 2, 1'b0, "R4");

    // R7: deceptive read disturb, two reads in a row
    setCfg(4, 7, 8, 1'b0, 1'b0);
    op(1'b1, 7, 1'b1, "R7");
    op(1'b0, 7, 1'b0, "R7");
    op(1'b0, 7, 1'b0, "R7");

    // R10: rising aggressor inverts victim
    setCfg(7, 9, 10, 1'b1, 1'b0);
    op(1'b1, 10, 1'b0, "R10");
    op(1'b1, 9, 1'b0, "R10");
    op(1'b1, 10, 1'b1, "R10");
    op(1'b0, 9, 1'b0, "R10");

    // R13: AND bridge
    setCfg(10, 11, 12, 1'b0, 1'b0);
    op(1'b1, 11, 1'b1, "R13");
    op(1'b1, 12, 1'b0, "R13");
    op(1'b0, 11, 1'b0, "R13");
    op(1'b0, 12, 1'b0, "R13");

    // Random mixes under every type plus unused code 13
    for (int t = 0; t <= 13; t++) begin
      if (t == 12) continue;
      for (int round = 0; round < 3; round++) begin
        int v = $urandom % DEPTH;
        int a = (v + 1 + ($urandom % (DEPTH - 1))) % DEPTH;
        setCfg(t, v, a, 1'($urandom), 1'($urandom));
        for (int k = 0; k < 60; k++) begin
          int sel = $urandom % 4;
          int ad = (sel == 0) ? v : (sel == 1) ? a : int'($urandom % DEPTH);
          op(1'($urandom), ad, 1'($urandom), tagOf(t));
        end
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule